// File: doc/BRIEF.md
# Escape Stream Decoder

This block sits between a byte source on the host side, such as a UART receiver, and an HDLC framer. The host carries frame boundaries in the same byte stream as the payload. It does so with two-byte escape sequences: a prefix byte (0x19) followed by a code byte. The decoder removes the escape layer. Ordinary bytes go through unchanged. A recognised code either becomes one substituted data byte or becomes an end-of-frame event. When the framer sees that event, it computes and appends the frame check sequence. An unknown code is dropped along with its prefix, and the decoder raises a one-cycle error pulse.

Both sides use a valid/ready handshake. Every result is registered. The input is held off (ready low) while an output beat waits for the framer. An escape prefix that is still waiting for its code byte survives such a stall.

Top module: `esc_stream_decoder`

## Requirements
- R1: Any byte other than 0x19 that is accepted with no escape pending appears unchanged on `out_data` with `out_valid`=1 and `out_eof`=0 in the cycle after it is accepted. Bytes leave in the order they arrived.
- R2: The accepted pair 0x19, 0xA0 produces exactly one data beat of 0x11.
- R3: The pair 0x19, 0xA1 produces one data beat of 0x13. The pair 0x19, 0x5C produces one data beat of 0x19.
- R4: The pair 0x19, 0xB1 produces one end-of-frame beat (`out_valid`=1, `out_eof`=1, `out_data`=0x00) and no data byte.
- R5: Accepting a 0x19 prefix produces no output beat and no error.
- R6: A 0x19 followed by any code other than 0xA0, 0xA1, 0x5C or 0xB1 produces no output beat. In that case `err_pulse` is high for exactly the one cycle after the code byte is accepted. The next byte is then treated as an ordinary byte.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data`/`out_eof` hold their values. An escape pending across such a stall is still resolved correctly afterwards.
- R8: After reset, `out_valid`=0, `err_pulse`=0 and `in_ready`=1, and no escape is pending. This holds even if reset arrived between a prefix and its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Decoder can accept a byte this cycle |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Decoded data byte (0 on end-of-frame beats) |
| out_eof | output | 1 | Beat is an end-of-frame event |
| out_ready | input | 1 | Framer accepts the output beat |
| err_pulse | output | 1 | One-cycle flag for a discarded unknown escape |

## Verification
Each result of this block is due one clock after the edge that accepts the deciding byte. This covers a data beat, an end-of-frame beat, the error pulse, and the absence of output after a prefix. The bench drives each byte on a falling edge and reads the outputs at the next falling edge, which is exactly one accepting edge later. Stall checks hold `out_ready` low and read `in_ready` and the held beat on every falling edge of the stall. They then release `out_ready` and confirm that the pending prefix still decodes.

// File: rtl/esc_pkg.sv
// Package: shared constants and types for the escape stream decoder.
// Assumes an 8-bit byte stream; the decoder modules take widths as parameters.
package esc_pkg;

    localparam int BYTE_W = 8;

    // Default escape prefix and frame-end code.
    localparam logic [BYTE_W-1:0] DEF_PREFIX   = 8'h19;
    localparam logic [BYTE_W-1:0] DEF_EOF_CODE = 8'hB1;

    // Default substitution map, entry 0 in the low bits.
    localparam int NUM_DEF_SUBS = 3;
    localparam logic [NUM_DEF_SUBS*BYTE_W-1:0] DEF_SUB_CODES = {8'h5C, 8'hA1, 8'hA0};
    localparam logic [NUM_DEF_SUBS*BYTE_W-1:0] DEF_SUB_VALS  = {8'h19, 8'h13, 8'h11};

    // Meaning of a code byte that follows the prefix.
    typedef enum logic [1:0] {
        CODE_DATA = 2'd0,
        CODE_EOF  = 2'd1,
        CODE_BAD  = 2'd2
    } code_kind_t;

endpackage

// File: rtl/esc_code_map.sv
// Module: esc_code_map
// Classifies the byte that follows an escape prefix. The result is a data
// substitution, an end-of-frame event, or an unknown code.
// Assumes the substitution codes are distinct from one another and from EOF_CODE.
module esc_code_map
    import esc_pkg::*;
#(
    parameter int                          DATA_W   = 8,
    parameter int                          NUM_SUBS = 3,
    parameter logic [DATA_W-1:0]           EOF_CODE = 8'hB1,
    parameter logic [NUM_SUBS*DATA_W-1:0]  SUB_CODES = {8'h5C, 8'hA1, 8'hA0},
    parameter logic [NUM_SUBS*DATA_W-1:0]  SUB_VALS  = {8'h19, 8'h13, 8'h11}
) (
    input  logic [DATA_W-1:0] code,
    output code_kind_t        kind,
    output logic [DATA_W-1:0] sub_data
);

    logic [NUM_SUBS-1:0] hit;

    // One comparator per substitution entry.
    for (genvar i = 0; i < NUM_SUBS; i++) begin : g_cmp
        assign hit[i] = (code == SUB_CODES[i*DATA_W +: DATA_W]);
    end

    // Merge the matching entry's value (at most one hits).
    always_comb begin
        sub_data = '0;
        for (int i = 0; i < NUM_SUBS; i++) begin
            if (hit[i]) begin
                sub_data = sub_data | SUB_VALS[i*DATA_W +: DATA_W];
            end
        end
    end

    // Pick the code class.
    always_comb begin
        if (code == EOF_CODE) begin
            kind = CODE_EOF;
        end else if (|hit) begin
            kind = CODE_DATA;
        end else begin
            kind = CODE_BAD;
        end
    end

endmodule

// File: rtl/esc_seq_fsm.sv
// Module: esc_seq_fsm
// Tracks whether an escape prefix is pending and decides what each accepted
// byte produces: a load into the output stage, or a registered error pulse.
// Assumes in_fire is asserted only when the output stage can take a load.
module esc_seq_fsm
    import esc_pkg::*;
#(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] PREFIX = 8'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_fire,
    input  logic [DATA_W-1:0] in_data,
    input  code_kind_t        kind,
    input  logic [DATA_W-1:0] sub_data,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic              load_eof,
    output logic              esc_pend,
    output logic              err_pulse
);

    logic esc_nxt;
    logic bad;

    // Work out the next state and the action for the byte being accepted.
    always_comb begin
        esc_nxt   = esc_pend;
        load      = 1'b0;
        load_data = in_data;
        load_eof  = 1'b0;
        bad       = 1'b0;
        if (in_fire) begin
            if (!esc_pend) begin
                if (in_data == PREFIX) begin
                    esc_nxt = 1'b1;
                end else begin
                    load = 1'b1;
                end
            end else begin
                esc_nxt = 1'b0;
                case (kind)
                    CODE_DATA: begin
                        load      = 1'b1;
                        load_data = sub_data;
                    end
                    CODE_EOF: begin
                        load      = 1'b1;
                        load_eof  = 1'b1;
                        load_data = '0;
                    end
                    default: bad = 1'b1;
                endcase
            end
        end
    end

    // Register the pending-escape flag and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_pend  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            esc_pend  <= esc_nxt;
            err_pulse <= bad;
        end
    end

    // R5
    prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && !esc_pend && in_data == PREFIX) |=> (esc_pend && !err_pulse));

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

endmodule

// File: rtl/esc_out_stage.sv
// Module: esc_out_stage
// A one-entry output register that carries the decoded beat to the framer.
// It is reloadable in the same cycle the current beat is taken.
// Assumes load is asserted only when can_take is high.
module esc_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_eof,
    input  logic              out_ready,
    output logic              can_take,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eof
);

    // Space is free when empty or when the held beat leaves this cycle.
    always_comb begin
        can_take = !out_valid || out_ready;
    end

    // Hold, replace or drain the output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_eof   <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
            out_eof   <= load_eof;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

    // R4
    eof_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |-> (out_data == '0));

endmodule

// File: rtl/esc_stream_decoder.sv
// Module: esc_stream_decoder (top)
// Removes the two-byte escape layer from a host byte stream. The result is a
// stream of data beats and end-of-frame beats for an HDLC framer, with an
// error pulse for unknown codes. Valid/ready handshake on both sides.
// Assumes codes in the map are distinct and differ from the EOF code.
module esc_stream_decoder
    import esc_pkg::*;
#(
    parameter int                          DATA_W    = BYTE_W,
    parameter int                          NUM_SUBS  = NUM_DEF_SUBS,
    parameter logic [DATA_W-1:0]           PREFIX    = DEF_PREFIX,
    parameter logic [DATA_W-1:0]           EOF_CODE  = DEF_EOF_CODE,
    parameter logic [NUM_SUBS*DATA_W-1:0]  SUB_CODES = DEF_SUB_CODES,
    parameter logic [NUM_SUBS*DATA_W-1:0]  SUB_VALS  = DEF_SUB_VALS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eof,
    input  logic              out_ready,
    output logic              err_pulse
);

    localparam logic [DATA_W-1:0] FIRST_SUB_CODE = SUB_CODES[DATA_W-1:0];
    localparam logic [DATA_W-1:0] FIRST_SUB_VAL  = SUB_VALS[DATA_W-1:0];

    code_kind_t        kind;
    logic [DATA_W-1:0] sub_data;
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic              load_eof;
    logic              esc_pend;
    logic              can_take;
    logic              in_fire;

    // Accept a host byte whenever the output stage has room.
    always_comb begin
        in_ready = can_take;
        in_fire  = in_valid && can_take;
    end

    esc_code_map #(
        .DATA_W    (DATA_W),
        .NUM_SUBS  (NUM_SUBS),
        .EOF_CODE  (EOF_CODE),
        .SUB_CODES (SUB_CODES),
        .SUB_VALS  (SUB_VALS)
    ) u_map (
        .code     (in_data),
        .kind     (kind),
        .sub_data (sub_data)
    );

    esc_seq_fsm #(
        .DATA_W (DATA_W),
        .PREFIX (PREFIX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_fire   (in_fire),
        .in_data   (in_data),
        .kind      (kind),
        .sub_data  (sub_data),
        .load      (load),
        .load_data (load_data),
        .load_eof  (load_eof),
        .esc_pend  (esc_pend),
        .err_pulse (err_pulse)
    );

    esc_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .load_eof  (load_eof),
        .out_ready (out_ready),
        .can_take  (can_take),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_eof   (out_eof)
    );

    // R7
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2
    sub_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && esc_pend && in_data == FIRST_SUB_CODE)
        |=> (out_valid && !out_eof && out_data == FIRST_SUB_VAL));

endmodule

// File: tb/esc_stream_decoder_tb.sv
`timescale 1ns/1ps
// Bench: a vector table walked by one loop, then directed reset and stall tests.
module esc_stream_decoder_tb;

    localparam int K_NONE = 0, K_DATA = 1, K_EOF = 2, K_ERR = 3;
    localparam int NV = 19;
    // {byte, expected kind, expected data}
    localparam logic [17:0] VEC [NV] = '{
        {8'hFF, 2'd1, 8'hFF}, {8'h00, 2'd1, 8'h00}, {8'h19, 2'd0, 8'h00},
        {8'hA0, 2'd1, 8'h11}, {8'h19, 2'd0, 8'h00}, {8'hA1, 2'd1, 8'h13},
        {8'h19, 2'd0, 8'h00}, {8'h5C, 2'd1, 8'h19}, {8'h19, 2'd0, 8'h00},
        {8'hB1, 2'd2, 8'h00}, {8'h7E, 2'd1, 8'h7E}, {8'h19, 2'd0, 8'h00},
        {8'h33, 2'd3, 8'h00}, {8'hA0, 2'd1, 8'hA0}, {8'h19, 2'd0, 8'h00},
        {8'h19, 2'd3, 8'h00}, {8'h11, 2'd1, 8'h11}, {8'h19, 2'd0, 8'h00},
        {8'hB1, 2'd2, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_ready = 1'b1;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_eof;
    logic       err_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    esc_stream_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_eof   (out_eof),
        .out_ready (out_ready),
        .err_pulse (err_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Observed beat: {valid, eof, err, data}, with eof/data masked when not valid.
    function automatic logic [31:0] seen();
        return {21'd0, out_valid, out_valid & out_eof, err_pulse,
                out_valid ? out_data : 8'h00};
    endfunction

    function automatic logic [31:0] want(input int k, input logic [7:0] d);
        case (k)
            K_DATA:  return {21'd0, 1'b1, 1'b0, 1'b0, d};
            K_EOF:   return {21'd0, 1'b1, 1'b1, 1'b0, 8'h00};
            K_ERR:   return {21'd0, 1'b0, 1'b0, 1'b1, 8'h00};
            default: return 32'd0;
        endcase
    endfunction

    // Drive a byte on a falling edge; return at the falling edge after acceptance.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R8: state held in reset
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 reset err_pulse", {31'd0, err_pulse}, 32'd0);
        check("R8 reset in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;

        // Table walk
        begin
            logic prev_esc = 1'b0;
            for (int i = 0; i < NV; i++) begin
                logic [7:0] b = VEC[i][17:10];
                int         k = int'(VEC[i][9:8]);
                logic [7:0] d = VEC[i][7:0];
                string      tag;
                send(b);
                case (k)
                    K_NONE:  tag = "R5 prefix";
                    K_EOF:   tag = "R4 end-of-frame";
                    K_ERR:   tag = "R6 unknown code";
                    default: tag = !prev_esc ? "R1 plain byte" :
                                   (d == 8'h11) ? "R2 sub A0" : "R3 sub A1/5C";
                endcase
                check(tag, seen(), want(k, d));
                prev_esc = (k == K_NONE);
            end
        end

        // R6: pulse lasts a single cycle
        send(8'h19);
        send(8'hEE);
        check("R6 pulse set", {31'd0, err_pulse}, 32'd1);
        @(negedge clk);
        check("R6 pulse cleared", {31'd0, err_pulse}, 32'd0);

        // R7: stall holds output and input, pending prefix survives
        out_ready = 1'b0;
        send(8'h41);
        check("R7 stalled beat", seen(), want(K_DATA, 8'h41));
        in_valid = 1'b1;
        in_data  = 8'h19;
        for (int j = 0; j < 3; j++) begin
            check("R7 in_ready low", {31'd0, in_ready}, 32'd0);
            @(negedge clk);
            check("R7 beat held", seen(), want(K_DATA, 8'h41));
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 prefix after stall", seen(), want(K_NONE, 8'h00));
        out_ready = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        send(8'hA1);
        check("R7 escape kept across stall", seen(), want(K_DATA, 8'h13));

        // R8: reset between prefix and code clears the pending escape
        send(8'h19);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 reset in_ready", {31'd0, in_ready}, 32'd1);
        rst_n = 1'b1;
        send(8'hA0);
        check("R8 no escape after reset", seen(), want(K_DATA, 8'hA0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule